// File: doc/BRIEF.md
# JTAG Stream Playback Controller

This block replays a pre-recorded boundary-scan bit stream from a byte-wide non-volatile memory into an IEEE 1149.1 device chain, with no host involved. After every reset, including power-on, it waits a programmable settling time so the chain can finish powering up. It then reads a four-byte length header from the start of the memory and plays the stream that follows, one TCK cycle per bit pair. When the stream is exhausted it releases the chain, turns off the memory and the indicator, and raises a done flag.

Each stream byte carries four TCK cycles. The even bit of each pair goes to TDI and the odd bit goes to TMS. The least significant pair is sent first, and no bit is inverted. The memory port is synchronous with one clock of read latency. The controller fetches one byte, plays its four cycles, and only then fetches the next byte. The TCK high and low phases are set in system clocks by parameters. TDI and TMS always settle at least one clock before TCK rises.

Top module: `jtag_stream_player`

## Requirements
- R1: While reset is asserted, jtagTck, jtagTdi and jtagTms are 0, chainRstN, memCeN and ledN are 1, and done is 0.
- R2: After reset is released, memCeN stays high for exactly DELAY_CYC clocks before the first memory access, and no TCK pulse occurs in that time.
- R3: Memory bytes 0 to 3 form a 32-bit end value, least significant byte at address 0. All four bytes take part in the end value.
- R4: Each stream byte produces four TCK pulses. Pulse k (k = 0 first) carries bit 2k on TDI and bit 2k+1 on TMS, without inversion.
- R5: Stream bytes are played from address 4 upward while the address is below the end value, so the total pulse count is 4 × (end − 4).
- R6: TCK is low at rest. Each high phase lasts exactly TCK_HI clocks, and each low phase between pulses lasts at least TCK_LO clocks. TDI and TMS hold steady for at least one clock before each rising edge and for the whole high phase.
- R7: At every TCK pulse, chainRstN, memCeN and ledN are all low.
- R8: After the last pulse, chainRstN, memCeN and ledN return high, TCK stays low, and done rises and stays high until the next reset.
- R9: An end value of 4 or less produces no TCK pulse and leads straight to the done state.
- R10: A reset in the middle of playback aborts it, and the whole sequence (delay, header, stream) runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; restarts the sequence |
| memAddr | output | ADDR_W | Read address to the stream memory |
| memRdata | input | 8 | Read data, valid one clock after the address |
| memCeN | output | 1 | Active-low memory chip enable |
| jtagTck | output | 1 | Chain test clock |
| jtagTms | output | 1 | Chain mode select |
| jtagTdi | output | 1 | Chain serial data |
| chainRstN | output | 1 | Active-low reset held on the chain during playback |
| ledN | output | 1 | Active-low busy indicator |
| done | output | 1 | Playback finished; sticky until reset |

## Verification
A wrong header byte lane or a wrong compare shows up only at the end of the run, as a pulse count that is wrong by a multiple of four. A wrong pair index or bit lane shows up at the first pulse that differs, as a TDI or TMS value that does not match the stored byte. A fault in the phase counter shows up within one pulse, as a wrong high width, or as a pin that changes too close to the rising edge. A wrong delay shows up as the memory enable falling too early or too late, counted in clocks from the reset release.

// File: rtl/jsp_pkg.sv
package jsp_pkg;

  typedef enum logic [3:0] {
    ST_WAIT, ST_HDR_REQ, ST_HDR_CAP, ST_CHECK, ST_FETCH,
    ST_LOAD, ST_SETUP, ST_HIGH, ST_LOW, ST_DONE
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic addrInc;
    logic hdrLoad;
    logic byteLoad;
    logic pinLoad;
    logic pairInc;
    logic tckHigh;
  } ctrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic delayDone;
    logic hiDone;
    logic loDone;
    logic hdrLast;
    logic pairLast;
    logic moreData;
  } stat_t;

endpackage

// File: rtl/jsp_datapath.sv
module jsp_datapath
  import jsp_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DELAY_CYC = 25_000_000,
  parameter int TCK_HI    = 2,
  parameter int TCK_LO    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             cmd,
  output stat_t             stat,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdata,
  output logic              tck,
  output logic              tms,
  output logic              tdi
);

  localparam int TMAX_A = (DELAY_CYC > TCK_HI) ? DELAY_CYC : TCK_HI;
  localparam int TMAX   = (TMAX_A > TCK_LO) ? TMAX_A : TCK_LO;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int HDR_W  = 32;

  logic [TW-1:0]    timerQ;
  logic [HDR_W-1:0] addrQ;
  logic [HDR_W-1:0] endQ;
  logic [7:0]       byteQ;
  logic [1:0]       pairQ;
  logic             tckQ, tmsQ, tdiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerQ <= '0;
    else if (cmd.timerClr) timerQ <= '0;
    else timerQ <= timerQ + TW'(1);
  end

  // one counter walks the header (0..3) and then the stream (4..)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (cmd.addrInc) addrQ <= addrQ + HDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) endQ <= '0;
    else if (cmd.hdrLoad) endQ[{addrQ[1:0], 3'b000} +: 8] <= memRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteQ <= '0;
      pairQ <= '0;
    end else if (cmd.byteLoad) begin
      byteQ <= memRdata;
      pairQ <= '0;
    end else if (cmd.pairInc) begin
      pairQ <= pairQ + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tckQ <= 1'b0;
      tdiQ <= 1'b0;
      tmsQ <= 1'b0;
    end else begin
      tckQ <= cmd.tckHigh;
      if (cmd.pinLoad) begin
        tdiQ <= byteQ[{pairQ, 1'b0}];
        tmsQ <= byteQ[{pairQ, 1'b1}];
      end
    end
  end

  assign memAddr        = addrQ[ADDR_W-1:0];
  assign tck            = tckQ;
  assign tdi            = tdiQ;
  assign tms            = tmsQ;
  assign stat.delayDone = (timerQ == TW'(DELAY_CYC - 1));
  assign stat.hiDone    = (timerQ == TW'(TCK_HI - 1));
  assign stat.loDone    = (timerQ == TW'(TCK_LO - 1));
  assign stat.hdrLast   = (addrQ[1:0] == 2'd3);
  assign stat.pairLast  = (pairQ == 2'd3);
  assign stat.moreData  = (addrQ < endQ);

  // R6: pins must already be settled when TCK rises
  p_pins_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tckQ) |-> $stable({tdiQ, tmsQ}));

  // R5: the address only ever steps forward by one
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrQ) |-> addrQ == $past(addrQ) + HDR_W'(1));

endmodule

// File: rtl/jsp_ctrl.sv
module jsp_ctrl
  import jsp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  stat_t stat,
  output ctrl_t cmd,
  output logic  active,
  output logic  done
);

  state_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_WAIT;
    else stateQ <= stateD;
  end

  always_comb begin
    cmd    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_WAIT: if (stat.delayDone) begin
        cmd.timerClr = 1'b1;
        stateD       = ST_HDR_REQ;
      end
      ST_HDR_REQ: stateD = ST_HDR_CAP;
      ST_HDR_CAP: begin
        cmd.hdrLoad = 1'b1;
        cmd.addrInc = 1'b1;
        stateD      = stat.hdrLast ? ST_CHECK : ST_HDR_REQ;
      end
      ST_CHECK: stateD = stat.moreData ? ST_FETCH : ST_DONE;
      ST_FETCH: stateD = ST_LOAD;
      ST_LOAD: begin
        cmd.byteLoad = 1'b1;
        stateD       = ST_SETUP;
      end
      ST_SETUP: begin
        cmd.pinLoad  = 1'b1;
        cmd.timerClr = 1'b1;
        stateD       = ST_HIGH;
      end
      ST_HIGH: begin
        cmd.tckHigh = 1'b1;
        if (stat.hiDone) begin
          cmd.timerClr = 1'b1;
          stateD       = ST_LOW;
        end
      end
      ST_LOW: if (stat.loDone) begin
        if (stat.pairLast) begin
          cmd.addrInc = 1'b1;
          stateD      = ST_CHECK;
        end else begin
          cmd.pairInc = 1'b1;
          stateD      = ST_SETUP;
        end
      end
      ST_DONE: stateD = ST_DONE;
      default: stateD = ST_WAIT;
    endcase
  end

  assign active = (stateQ != ST_WAIT) && (stateQ != ST_DONE);
  assign done   = (stateQ == ST_DONE);

  // R8: completion holds until reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

endmodule

// File: rtl/jtag_stream_player.sv
module jtag_stream_player
  import jsp_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DELAY_CYC = 25_000_000,
  parameter int TCK_HI    = 2,
  parameter int TCK_LO    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdata,
  output logic              memCeN,
  output logic              jtagTck,
  output logic              jtagTms,
  output logic              jtagTdi,
  output logic              chainRstN,
  output logic              ledN,
  output logic              done
);

  ctrl_t cmd;
  stat_t stat;
  logic  active;

  jsp_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .cmd    (cmd),
    .active (active),
    .done   (done)
  );

  jsp_datapath #(
    .ADDR_W    (ADDR_W),
    .DELAY_CYC (DELAY_CYC),
    .TCK_HI    (TCK_HI),
    .TCK_LO    (TCK_LO)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .stat     (stat),
    .memAddr  (memAddr),
    .memRdata (memRdata),
    .tck      (jtagTck),
    .tms      (jtagTms),
    .tdi      (jtagTdi)
  );

  assign memCeN    = !active;
  assign chainRstN = !active;
  assign ledN      = !active;

  // R7: every pulse happens inside the active window
  p_pulse_active_r7: assert property (@(posedge clk) disable iff (!rstN)
    jtagTck |-> (!memCeN && !chainRstN && !ledN));

  // R8: quiet outputs once finished
  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!jtagTck && memCeN && chainRstN && ledN));

endmodule

// File: tb/jtag_stream_player_tb.sv
module jtag_stream_player_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int DELAY_CYC  = 20;
  localparam int TCK_HI     = 2;
  localparam int TCK_LO     = 3;
  localparam int MEM_N      = 1 << ADDR_W;
  localparam int SEEN_N     = 4096;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memRdata = '0;
  logic              memCeN, jtagTck, jtagTms, jtagTdi, chainRstN, ledN, done;

  logic [7:0] mem [0:MEM_N-1];

  int total = 0;
  int bad   = 0;

  // monitor state
  int         pulseCnt, widthErr, setupErr, activeErr, hiRun, loRun;
  logic [1:0] seen [0:SEEN_N-1];
  logic       prevTck, prevTdi, prevTms;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (!memCeN) memRdata <= mem[memAddr];

  jtag_stream_player #(
    .ADDR_W(ADDR_W), .DELAY_CYC(DELAY_CYC), .TCK_HI(TCK_HI), .TCK_LO(TCK_LO)
  ) u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdata(memRdata),
    .memCeN(memCeN), .jtagTck(jtagTck), .jtagTms(jtagTms), .jtagTdi(jtagTdi),
    .chainRstN(chainRstN), .ledN(ledN), .done(done)
  );

  // pulse monitor, one sample per clock away from the rising edge
  always @(negedge clk) begin
    if (!rstN) begin
      prevTck = 1'b0; prevTdi = 1'b0; prevTms = 1'b0;
      hiRun = 0; loRun = 0;
    end else begin
      if (jtagTck && !prevTck) begin
        if (jtagTdi !== prevTdi || jtagTms !== prevTms) setupErr++;
        if (pulseCnt > 0 && loRun < TCK_LO) widthErr++;
        if (memCeN || chainRstN || ledN) activeErr++;
        if (pulseCnt < SEEN_N) seen[pulseCnt] = {jtagTms, jtagTdi};
        pulseCnt++;
        hiRun = 1;
      end else if (jtagTck) begin
        if (jtagTdi !== prevTdi || jtagTms !== prevTms) setupErr++;
        hiRun++;
      end else if (prevTck) begin
        if (hiRun != TCK_HI) widthErr++;
        loRun = 1;
      end else begin
        loRun++;
      end
      prevTck = jtagTck; prevTdi = jtagTdi; prevTms = jtagTms;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic loadStream(input int endVal, input int seed);
    for (int a = 0; a < MEM_N; a++) mem[a] = 8'((a * 29 + seed * 7 + 3) ^ (a >> 3));
    mem[0] = endVal[7:0];
    mem[1] = endVal[15:8];
    mem[2] = endVal[23:16];
    mem[3] = endVal[31:24];
  endtask

  task automatic holdReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    pulseCnt = 0; widthErr = 0; setupErr = 0; activeErr = 0;
  endtask

  task automatic waitDone(input int maxCyc, input string req);
    int n = 0;
    while (!done && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
    chk({req, " done reached"}, int'(done), 1);
  endtask

  function automatic int mismatches();
    int m = 0;
    for (int i = 0; i < pulseCnt && i < SEEN_N; i++) begin
      logic [7:0] b = mem[4 + i / 4];
      int k = i % 4;
      if (seen[i] !== {b[2*k+1], b[2*k]}) m++;
    end
    return m;
  endfunction

  // R1
  task automatic t_reset();
    holdReset();
    chk("R1 tck/tdi/tms low in reset", int'({jtagTck, jtagTdi, jtagTms}), 0);
    chk("R1 ceN/chainRstN/ledN high in reset", int'({memCeN, chainRstN, ledN}), 7);
    chk("R1 done low in reset", int'(done), 0);
  endtask

  // R2
  task automatic t_delay();
    int n = 0;
    loadStream(6, 1);
    holdReset();
    rstN = 1'b1;
    while (memCeN && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R2 clocks before first memory access", n, DELAY_CYC);
    chk("R2 no pulse during delay", pulseCnt, 0);
    waitDone(2000, "R2");
  endtask

  // R4 R5 R6 R7 R8
  task automatic t_basic();
    loadStream(8, 2);
    mem[4] = 8'hB4; mem[5] = 8'h1E; mem[6] = 8'hC9; mem[7] = 8'h63;
    holdReset();
    rstN = 1'b1;
    waitDone(5000, "R5");
    chk("R5 pulse count for end=8", pulseCnt, 16);
    chk("R4 bit pair order and polarity", mismatches(), 0);
    chk("R6 phase widths", widthErr, 0);
    chk("R6 pins stable around rise", setupErr, 0);
    chk("R7 chain held during pulses", activeErr, 0);
    chk("R8 outputs released", int'({memCeN, chainRstN, ledN, jtagTck}), 14);
    repeat (50) @(negedge clk);
    chk("R8 done sticky", int'(done), 1);
    chk("R8 no pulse after done", pulseCnt, 16);
  endtask

  // R3: upper header byte counts
  task automatic t_header();
    loadStream(32'h0000_0109, 3);
    holdReset();
    rstN = 1'b1;
    waitDone(20000, "R3");
    chk("R3 little-endian end value", pulseCnt, (32'h109 - 4) * 4);
    chk("R3 long stream contents", mismatches(), 0);
    chk("R6 phase widths long stream", widthErr + setupErr, 0);
  endtask

  // R9
  task automatic t_empty(input int endVal);
    loadStream(endVal, 4);
    holdReset();
    rstN = 1'b1;
    waitDone(500, "R9");
    repeat (5) @(negedge clk);
    chk("R9 no pulses for short end value", pulseCnt, 0);
    chk("R9 released after empty stream", int'({memCeN, chainRstN, ledN}), 7);
  endtask

  // R10
  task automatic t_restart();
    int n = 0;
    loadStream(40, 5);
    holdReset();
    rstN = 1'b1;
    while (pulseCnt < 10 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 playback under way", int'(pulseCnt >= 10), 1);
    holdReset();
    chk("R10 idle while reset mid-stream", int'({jtagTck, memCeN, chainRstN, ledN, done}), 14);
    rstN = 1'b1;
    waitDone(5000, "R10");
    chk("R10 full rerun pulse count", pulseCnt, 144);
    chk("R10 rerun starts at first byte", mismatches(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    pulseCnt = 0; widthErr = 0; setupErr = 0; activeErr = 0;
    t_reset();
    t_delay();
    t_basic();
    t_header();
    t_empty(4);
    t_empty(2);
    t_restart();
    finishRun();
  end

endmodule